// File: doc/BRIEF.md
# Protected Motor-Control PWM Core

This block drives six PWM pins organised as three complementary pairs: pin 2p is the top output of pair p and pin 2p+1 is its bottom output. One shared counter produces either an edge-aligned (sawtooth) or a center-aligned (up/down) time base. Each pair compares the counter with its own active duty value, and the bottom output is the complement of the top output. Duty values arrive on input ports. They move into the active compare registers only when a period ends.

A small register file holds the configuration and guards it with two levels of protection. A sticky lock bit freezes the alignment, polarity and secondary-enable fields. The secondary-enable bit in turn freezes the pair-swap and duty-source fields. The per-pin mask field has no protection at all.

Two state flags from the chip mark the debug and wait states. In either state the duty reloads stop. The outputs are also forced inactive unless the matching run bit is set. The counter keeps running in both states, so the waveform returns in phase when the state ends. The pair count is fixed at 3 by the 8-bit register layout. The period is a parameter (default 10).

Top module: `mc_pwm_core`

## Requirements
- R1: After reset every register field reads 0. With the active duties at 0, the outputs are top pins low and bottom pins high (pwm_o = 6'b101010).
- R2: With the alignment bit (CTRL bit 0) at 1, the counter runs 0..PERIOD-1 and wraps to 0. A top output is active while counter < active duty.
- R3: With the alignment bit at 0, the counter runs 0,1..PERIOD,PERIOD-1..1,0 and repeats. A top output is active while counter < active duty.
- R4: The polarity bit (CTRL bit 1) makes a top pin low when active and high when inactive. Bottom pins stay active-high.
- R5: The bottom pin 2p+1 carries the inverse activity of the top pin 2p in the same pair.
- R6: While dbg_i is 1 and the debug-run bit (CFG bit 1) is 0, every channel is inactive: top pins sit at the polarity bit's value and bottom pins are low. Normal output resumes when dbg_i falls.
- R7: While wait_i is 1 and the wait-run bit (CFG bit 2) is 0, every channel is inactive in the same way as in R6. Normal output resumes when wait_i falls.
- R8: The active duties load from duty_i only at the clock edge that ends a period, and only while dbg_i and wait_i are both 0.
- R9: The lock bit (CFG bit 0) can only be set, and reset clears it. While it is set, writes to CTRL have no effect.
- R10: While the secondary-enable bit (CTRL bit 3) is 1, writes to MODE (swap bits [2:0], duty-source bits [5:4]) have no effect.
- R11: MASK bits [5:0] (address 3) can be written in every protection state. A set mask bit forces that pin's channel inactive.
- R12: CTRL bit 2 always reads 0.
- R13: A set MODE swap bit p exchanges the activity of pins 2p and 2p+1. Top-pin polarity still applies to pin 2p.
- R14: A nonzero MODE duty-source value s makes every pair load the duty of pair s-1. A value of 0 makes each pair load its own duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 CFG, 1 CTRL, 2 MODE, 3 MASK |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Combinational read data at addr_i |
| dbg_i | input | 1 | Chip is in debug state |
| wait_i | input | 1 | Chip is in wait state |
| duty_i | input | 3*CNT_W | Buffered duty per pair, pair p at bits [p*CNT_W +: CNT_W] |
| pwm_o | output | 6 | PWM pins; even index is the top output, odd index the bottom output |

## Verification
The bench targets four kinds of corner case:
- Duty changes that arrive while dbg_i or wait_i is high. A core that reloads anyway would shift the duty at the next period end.
- Changes to the alignment bit in the middle of a period, including during the down count. A counter that keeps its down direction after switching to edge mode would run backwards or overrun the period.
- Writes after the lock bit or the secondary-enable bit is set. A leaky lock would show a changed readback or a different waveform. Mask writes must still land in that state.
- Gating while polarity inversion or pair swap is active. A core that gates before applying polarity, or gates only the top pins, would show the wrong idle levels.

// File: rtl/mc_pwm_pkg.sv
package mc_pwm_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_MODE = 2'd2,
    ADDR_MASK = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic lock;
    logic dbg_run;
    logic wait_run;
    logic edge_al;
    logic top_neg;
    logic sec_en;
  } cfg_t;
endpackage

// File: rtl/mc_pwm_regs.sv
module mc_pwm_regs
  import mc_pwm_pkg::*;
#(
  parameter int NPAIR  = 3,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output cfg_t                 cfg_o,
  output logic [NPAIR-1:0]     swap_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic [2*NPAIR-1:0]   mask_o
);
  localparam int NCH   = 2 * NPAIR;
  localparam int SEL_LO = 4;

  cfg_t               cfg_q;
  logic [NPAIR-1:0]   swap_q;
  logic [SEL_W-1:0]   sel_q;
  logic [NCH-1:0]     mask_q;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      swap_q <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr)
        ADDR_CFG: begin
          cfg_q.lock     <= cfg_q.lock | wdata_i[0];
          cfg_q.dbg_run  <= wdata_i[1];
          cfg_q.wait_run <= wdata_i[2];
        end
        ADDR_CTRL: if (!cfg_q.lock) begin
          cfg_q.edge_al <= wdata_i[0];
          cfg_q.top_neg <= wdata_i[1];
          cfg_q.sec_en  <= wdata_i[3];
        end
        ADDR_MODE: if (!cfg_q.sec_en) begin
          swap_q <= wdata_i[NPAIR-1:0];
          sel_q  <= wdata_i[SEL_LO +: SEL_W];
        end
        ADDR_MASK: mask_q <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_CFG: begin
        rdata_o[0] = cfg_q.lock;
        rdata_o[1] = cfg_q.dbg_run;
        rdata_o[2] = cfg_q.wait_run;
      end
      ADDR_CTRL: begin
        rdata_o[0] = cfg_q.edge_al;
        rdata_o[1] = cfg_q.top_neg;
        rdata_o[3] = cfg_q.sec_en;
      end
      ADDR_MODE: begin
        rdata_o[NPAIR-1:0]       = swap_q;
        rdata_o[SEL_LO +: SEL_W] = sel_q;
      end
      ADDR_MASK: rdata_o[NCH-1:0] = mask_q;
      default: ;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign swap_o = swap_q;
  assign sel_o  = sel_q;
  assign mask_o = mask_q;

  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> cfg_q.lock);
  assert_ctrl_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> $stable({cfg_q.edge_al, cfg_q.top_neg, cfg_q.sec_en}));
  assert_mode_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.sec_en |=> $stable({swap_q, sel_q}));
endmodule

// File: rtl/mc_pwm_counter.sv
module mc_pwm_counter #(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_al_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bound_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (edge_al_i) begin
      down_q <= 1'b0;
      cnt_q  <= (cnt_q >= LAST) ? '0 : cnt_q + ONE;
    end else if (!down_q) begin
      if (cnt_q >= TOP) begin
        down_q <= 1'b1;
        cnt_q  <= LAST;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else if (cnt_q <= ONE) begin
      down_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // period end: next count is 0
  assign bound_o = edge_al_i ? (cnt_q >= LAST) : (down_q && cnt_q <= ONE);
  assign cnt_o   = cnt_q;

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  assert_edge_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_al_i && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/mc_pwm_outs.sv
module mc_pwm_outs #(
  parameter int NPAIR = 3,
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [NPAIR*CNT_W-1:0] duty_i,
  input  logic [NPAIR-1:0]       swap_i,
  input  logic [2*NPAIR-1:0]     mask_i,
  input  logic                   top_neg_i,
  input  logic                   gate_i,
  output logic [2*NPAIR-1:0]     pwm_o
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic act, act_top, act_bot;
    assign act     = cnt_i < duty_i[p*CNT_W +: CNT_W];
    assign act_top = (swap_i[p] ? ~act : act) & ~gate_i & ~mask_i[2*p];
    assign act_bot = (swap_i[p] ? act : ~act) & ~gate_i & ~mask_i[2*p+1];
    assign pwm_o[2*p]   = act_top ^ top_neg_i;
    assign pwm_o[2*p+1] = act_bot;
  end
endmodule

// File: rtl/mc_pwm_core.sv
module mc_pwm_core
  import mc_pwm_pkg::*;
#(
  parameter int NPAIR  = 3,
  parameter int CNT_W  = 8,
  parameter int PERIOD = 10,
  parameter int DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [1:0]             addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic                   dbg_i,
  input  logic                   wait_i,
  input  logic [NPAIR*CNT_W-1:0] duty_i,
  output logic [2*NPAIR-1:0]     pwm_o
);
  localparam int SEL_W = 2;

  cfg_t                   cfg;
  logic [NPAIR-1:0]       swap;
  logic [SEL_W-1:0]       sel;
  logic [2*NPAIR-1:0]     mask;
  logic [CNT_W-1:0]       cnt;
  logic                   bound, freeze, gate, load;
  logic [NPAIR*CNT_W-1:0] duty_src, duty_act_q;

  mc_pwm_regs #(.NPAIR(NPAIR), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .cfg_o(cfg), .swap_o(swap), .sel_o(sel), .mask_o(mask)
  );

  mc_pwm_counter #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_cnt (
    .clk_i, .rst_ni, .edge_al_i(cfg.edge_al), .cnt_o(cnt), .bound_o(bound)
  );

  assign freeze = dbg_i | wait_i;
  assign gate   = (dbg_i & ~cfg.dbg_run) | (wait_i & ~cfg.wait_run);
  assign load   = bound & ~freeze;

  // duty source: 0 = own pair, s = pair s-1 for all
  always_comb begin
    for (int p = 0; p < NPAIR; p++) begin
      if (sel == '0 || int'(sel) > NPAIR)
        duty_src[p*CNT_W +: CNT_W] = duty_i[p*CNT_W +: CNT_W];
      else
        duty_src[p*CNT_W +: CNT_W] = duty_i[(int'(sel)-1)*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_act_q <= '0;
    else if (load) duty_act_q <= duty_src;
  end

  mc_pwm_outs #(.NPAIR(NPAIR), .CNT_W(CNT_W)) u_outs (
    .cnt_i(cnt), .duty_i(duty_act_q), .swap_i(swap), .mask_i(mask),
    .top_neg_i(cfg.top_neg), .gate_i(gate), .pwm_o
  );

  assert_freeze_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze |=> $stable(duty_act_q));
  assert_gate_bottom_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_i && !cfg.dbg_run) |-> (pwm_o & {NPAIR{2'b10}}) == '0);
  assert_gate_bottom_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !cfg.wait_run) |-> (pwm_o & {NPAIR{2'b10}}) == '0);
endmodule

// File: tb/mc_pwm_core_test.sv
module mc_pwm_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 3;
  localparam int CNT_W = 8;
  localparam int PER   = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, dbg = 1'b0, wt = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NPAIR*CNT_W-1:0] duty = '0;
  logic [5:0] pwm;

  int errors = 0, checks = 0;

  mc_pwm_core #(.NPAIR(NPAIR), .CNT_W(CNT_W), .PERIOD(PER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .dbg_i(dbg), .wait_i(wt), .duty_i(duty), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int m_cnt, m_down;
  int m_duty [NPAIR];
  logic m_lock, m_drun, m_wrun, m_edge, m_neg, m_sec;
  logic [2:0] m_swap;
  logic [1:0] m_sel;
  logic [5:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0;
      for (int p = 0; p < NPAIR; p++) m_duty[p] = 0;
      {m_lock, m_drun, m_wrun, m_edge, m_neg, m_sec} = '0;
      m_swap = '0; m_sel = '0; m_mask = '0;
    end else begin
      logic bnd;
      bnd = m_edge ? (m_cnt >= PER-1) : (m_down == 1 && m_cnt <= 1);
      if (bnd && !dbg && !wt)
        for (int p = 0; p < NPAIR; p++)
          m_duty[p] = (m_sel == 0) ? int'(duty[p*CNT_W +: CNT_W])
                                   : int'(duty[(int'(m_sel)-1)*CNT_W +: CNT_W]);
      if (m_edge) begin
        m_down = 0; m_cnt = (m_cnt >= PER-1) ? 0 : m_cnt + 1;
      end else if (m_down == 0) begin
        if (m_cnt >= PER) begin m_down = 1; m_cnt = PER-1; end
        else m_cnt = m_cnt + 1;
      end else if (m_cnt <= 1) begin m_down = 0; m_cnt = 0; end
      else m_cnt = m_cnt - 1;
      if (wr_en) begin
        case (addr)
          2'd0: begin m_lock = m_lock | wdata[0]; m_drun = wdata[1]; m_wrun = wdata[2]; end
          2'd1: if (!m_lock) begin m_edge = wdata[0]; m_neg = wdata[1]; m_sec = wdata[3]; end
          2'd2: if (!m_sec) begin m_swap = wdata[2:0]; m_sel = wdata[5:4]; end
          default: m_mask = wdata[5:0];
        endcase
      end
    end
  end

  function automatic logic [5:0] exp_pwm();
    logic [5:0] r;
    logic g, a, at, ab;
    g = (dbg && !m_drun) || (wt && !m_wrun);
    for (int p = 0; p < NPAIR; p++) begin
      a  = m_cnt < m_duty[p];
      at = (m_swap[p] ? !a : a) && !g && !m_mask[2*p];
      ab = (m_swap[p] ? a : !a) && !g && !m_mask[2*p+1];
      r[2*p] = at ^ m_neg; r[2*p+1] = ab;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {5'd0, m_wrun, m_drun, m_lock};
      2'd1: return {4'd0, m_sec, 1'b0, m_neg, m_edge};
      2'd2: return {2'd0, m_sel, 1'b0, m_swap};
      default: return {2'd0, m_mask};
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // output check; covers R5 and R8 on every cycle
  task automatic chk_out();
    string tag;
    if (dbg && !m_drun) tag = "R6";
    else if (wt && !m_wrun) tag = "R7";
    else if (m_mask != 0) tag = "R11";
    else if (m_swap != 0) tag = "R13";
    else if (m_sel != 0) tag = "R14";
    else if (m_neg) tag = "R4";
    else if (m_edge) tag = "R2";
    else tag = "R3";
    chk(tag, {2'b0, pwm}, {2'b0, exp_pwm()});
  endtask

  task automatic chk_rd();
    string tag;
    case (addr)
      2'd0: tag = "R9";
      2'd1: tag = "R12";
      2'd2: tag = "R10";
      default: tag = "R11";
    endcase
    chk(tag, rdata, exp_rd(addr));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    chk_out();
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    chk_out();
    wr_en = 1'b0;
    #1;
    chk_rd();
  endtask

  task automatic rand_run(input int n, input logic allow_lock);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_out();
      chk_rd();
      wr_en = ($urandom_range(0, 15) == 0);
      addr  = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      if (!allow_lock && addr == 2'd0) wdata[0] = 1'b0;
      if ($urandom_range(0, 40) == 0) dbg = ~dbg;
      if ($urandom_range(0, 40) == 0) wt = ~wt;
      if ($urandom_range(0, 3) == 0)
        for (int p = 0; p < NPAIR; p++)
          duty[p*CNT_W +: CNT_W] = CNT_W'($urandom_range(0, PER+1));
    end
    @(negedge clk);
    wr_en = 1'b0; dbg = 1'b0; wt = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", {2'b0, pwm}, 8'b0010_1010);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1", rdata, 8'h00);
    end
    // R12: reserved bit reads 0
    wr(2'd1, 8'hFF);
    addr = 2'd1; #1;
    chk("R12", rdata, 8'h0B);
    wr(2'd1, 8'h01);
    // R8: duty held across debug with run enabled
    wr(2'd0, 8'h02);
    duty = {8'd3, 8'd6, 8'd9};
    repeat (2 * PER) begin @(negedge clk); chk_out(); end
    dbg = 1'b1;
    duty = {8'd1, 8'd1, 8'd1};
    repeat (3 * PER) begin @(negedge clk); chk_out(); end
    dbg = 1'b0;
    repeat (2 * PER) begin @(negedge clk); chk_out(); end
    rand_run(3000, 1'b0);
    // R10: secondary enable blocks MODE
    wr(2'd2, 8'h15);
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h22);
    addr = 2'd2; #1;
    chk("R10", rdata, 8'h15);
    rand_run(1500, 1'b0);
    // R9: lock is sticky and blocks CTRL
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    addr = 2'd0; #1;
    chk("R9", rdata, 8'h01);
    wr(2'd1, 8'h09);
    addr = 2'd1; #1;
    chk("R9", rdata, 8'h02);
    // R11: mask still writable when locked
    wr(2'd3, 8'h3F);
    addr = 2'd3; #1;
    chk("R11", rdata, 8'h3F);
    wr(2'd3, 8'h00);
    rand_run(2000, 1'b1);
    finish_run();
  end
endmodule